// File: doc/BRIEF.md
# Conditional trap compare unit

This unit decides whether a conditional trap should be taken for a pair of register operands. Each cycle it may receive two operands, a five-bit condition mask and a width select. It evaluates five relations between the operands: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. The mask chooses which of these relations count. If any chosen relation holds, the unit raises a trap pulse.

The width select picks between a full 64-bit comparison and a 32-bit comparison. In the 32-bit case only the low halves of the operands take part. The decision is registered, so the trap pulse appears one clock after the cycle in which the request was presented. The unit does not vector to a handler, record an error code or touch the program counter. Those jobs belong to the logic that consumes the pulse.

The unit has no states to step through. Its only storage is the trap register: reset forces it low, and each clock edge loads it with the decision for that cycle.

Top module: `trapcmp_unit`

## Requirements
- R1: Mask bit 4 (value 5'h10) enables a trap when operand A is less than operand B as signed numbers.
- R2: Mask bit 3 (value 5'h08) enables a trap when operand A is greater than operand B as signed numbers.
- R3: Mask bit 2 (value 5'h04) enables a trap when operand A equals operand B.
- R4: Mask bit 1 (value 5'h02) enables a trap when operand A is less than operand B as unsigned numbers.
- R5: Mask bit 0 (value 5'h01) enables a trap when operand A is greater than operand B as unsigned numbers.
- R6: The trap is the OR of all enabled relations that hold, so several mask bits may be set together. A mask of 5'h00 never traps.
- R7: With `dword_i` low (32-bit mode), both operands are reduced to bits 31:0 and compared as 32-bit signed and unsigned values. Bits 63:32 have no effect on the result.
- R8: `trap_o` is high for exactly one cycle, on the clock edge after a cycle with `valid_i` high and a true decision. It is low in every other cycle.
- R9: A synchronous active-high `rst_i` clears `trap_o`. A request presented in the same cycle as reset produces no trap.
- R10: A mask of 5'h1F traps for every operand pair in both width modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | A request is present this cycle |
| dword_i | input | 1 | 1 selects the 64-bit comparison, 0 selects the 32-bit comparison |
| mask_i | input | 5 | Condition mask: bit 4 signed less, bit 3 signed greater, bit 2 equal, bit 1 unsigned less, bit 0 unsigned greater |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| trap_o | output | 1 | Registered trap pulse |

## Verification
The hardest cases to reach are those where relations that usually agree give opposite answers. One case is an operand pair whose signed and unsigned orders disagree because bit 31 or bit 63 is set. Another is a 32-bit request whose upper halves would reverse the answer if they were included. Random operands rarely produce these exact pairs, so the stimulus places them on purpose: equal low words under different upper words, and most-negative against most-positive values in both widths. Each such pair is run under single-bit masks, so that each relation is observed on its own. The stimulus also presents a request during reset and runs back-to-back requests, to check that each pulse belongs to exactly one request.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;
    localparam int MASK_W = 5;

    // Field order gives the mask bit positions: slt is bit 4, ugt is bit 0.
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;
endpackage

// File: rtl/trapcmp_widen.sv
module trapcmp_widen #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] op_i,
    input  logic              dword_i,
    output logic [DATA_W-1:0] sx_o,
    output logic [DATA_W-1:0] zx_o
);
    localparam int UPPER_W = DATA_W - WORD_W;

    logic [WORD_W-1:0] low_w;

    assign low_w = op_i[WORD_W-1:0];

    always_comb begin
        if (dword_i) begin
            sx_o = op_i;
            zx_o = op_i;
        end else begin
            sx_o = {{UPPER_W{low_w[WORD_W-1]}}, low_w};
            zx_o = {{UPPER_W{1'b0}}, low_w};
        end
    end
endmodule

// File: rtl/trapcmp_relate.sv
module trapcmp_relate
    import trapcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              dword_i,
    output rel_t              rel_o
);
    localparam int N_OPS = 2;

    logic [DATA_W-1:0] op_in [N_OPS];
    logic [DATA_W-1:0] sx    [N_OPS];
    logic [DATA_W-1:0] zx    [N_OPS];

    assign op_in[0] = opa_i;
    assign op_in[1] = opb_i;

    for (genvar g = 0; g < N_OPS; g++) begin : g_widen
        trapcmp_widen #(
            .DATA_W (DATA_W),
            .WORD_W (WORD_W)
        ) i_widen (
            .op_i    (op_in[g]),
            .dword_i (dword_i),
            .sx_o    (sx[g]),
            .zx_o    (zx[g])
        );
    end

    always_comb begin
        rel_o.slt = $signed(sx[0]) < $signed(sx[1]);
        rel_o.sgt = $signed(sx[0]) > $signed(sx[1]);
        rel_o.eq  = zx[0] == zx[1];
        rel_o.ult = zx[0] < zx[1];
        rel_o.ugt = zx[0] > zx[1];
    end
endmodule

// File: rtl/trapcmp_select.sv
module trapcmp_select
    import trapcmp_pkg::*;
(
    input  rel_t              rel_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              hit_o
);
    logic [MASK_W-1:0] enabled;

    assign enabled = mask_i & rel_i;
    assign hit_o   = |enabled;
endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
    import trapcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic              dword_i,
    input  logic [4:0]        mask_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              trap_o
);
    rel_t rel;
    logic hit;
    logic trap_q;

    trapcmp_relate #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) i_relate (
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .dword_i (dword_i),
        .rel_o   (rel)
    );

    trapcmp_select i_select (
        .rel_i  (rel),
        .mask_i (mask_i),
        .hit_o  (hit)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            trap_q <= 1'b0;
        end else begin
            trap_q <= valid_i & hit;
        end
    end

    assign trap_o = trap_q;

    // R8
    no_spurious_trap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        trap_o |-> $past(valid_i));

    // R6
    zero_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && mask_i == 5'h00) |=> !trap_o);

    // R10
    full_mask_trap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && mask_i == 5'h1F) |=> trap_o);

    // R9
    reset_clears_chk: assert property (@(posedge clk_i)
        rst_i |=> !trap_o);

    // R1 R2 R3
    signed_trichotomy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({rel.slt, rel.sgt, rel.eq}) == 1);

    // R3 R4 R5
    unsigned_trichotomy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({rel.ult, rel.ugt, rel.eq}) == 1);
endmodule

// File: tb/test_trapcmp_unit.sv
module test_trapcmp_unit;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        valid_i = 1'b0;
    logic        dword_i = 1'b0;
    logic [4:0]  mask_i = 5'h00;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic        trap_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk_i = ~clk_i;

    trapcmp_unit i_trapcmp_unit (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_i),
        .dword_i (dword_i),
        .mask_i  (mask_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .trap_o  (trap_o)
    );

    function automatic bit model(input bit dw, input bit [4:0] m,
                                 input bit [63:0] a, input bit [63:0] b);
        bit slt, sgt, eq, ult, ugt;
        if (dw) begin
            slt = $signed(a) < $signed(b);
            sgt = $signed(a) > $signed(b);
            eq  = a == b;
            ult = a < b;
            ugt = a > b;
        end else begin
            slt = $signed(a[31:0]) < $signed(b[31:0]);
            sgt = $signed(a[31:0]) > $signed(b[31:0]);
            eq  = a[31:0] == b[31:0];
            ult = a[31:0] < b[31:0];
            ugt = a[31:0] > b[31:0];
        end
        return (m[4] & slt) | (m[3] & sgt) | (m[2] & eq) | (m[1] & ult) | (m[0] & ugt);
    endfunction

    task automatic apply(input bit rst, input bit v, input bit dw, input bit [4:0] m,
                         input bit [63:0] a, input bit [63:0] b, input string tag);
        item_t it;
        @(negedge clk_i);
        rst_i   = rst;
        valid_i = v;
        dword_i = dw;
        mask_i  = m;
        opa_i   = a;
        opb_i   = b;
        it.exp  = !rst && v && model(dw, m, a, b);
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: each request's result is visible just after the next rising edge.
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (trap_o !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%0b expected=%0b", it.tag, trap_o, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit [63:0] ra, rb;
        repeat (3) @(posedge clk_i);
        #1;
        // R9 reset state
        checks++;
        if (trap_o !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset actual=%0b expected=0", trap_o);
        end

        // R1 signed less: -1 < 1 (unsigned would be greater)
        apply(0, 1, 1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R1");
        apply(0, 1, 1, 5'h10, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
        // R2 signed greater
        apply(0, 1, 1, 5'h08, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R2");
        apply(0, 1, 1, 5'h08, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R2");
        // R3 equality
        apply(0, 1, 1, 5'h04, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R3");
        apply(0, 1, 1, 5'h04, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, "R3");
        // R4 unsigned less
        apply(0, 1, 1, 5'h02, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        apply(0, 1, 1, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R4");
        // R5 unsigned greater
        apply(0, 1, 1, 5'h01, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R5");
        apply(0, 1, 1, 5'h01, 64'd5, 64'd5, "R5");
        // R6 zero mask and combined masks
        apply(0, 1, 1, 5'h00, 64'd3, 64'd9, "R6");
        apply(0, 1, 0, 5'h00, 64'd9, 64'd3, "R6");
        apply(0, 1, 1, 5'h0C, 64'd2, 64'd7, "R6");
        apply(0, 1, 1, 5'h12, 64'd2, 64'd7, "R6");
        // R7 word mode: upper halves differ, low halves equal / reversed
        apply(0, 1, 0, 5'h04, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, "R7");
        apply(0, 1, 0, 5'h1B, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, "R7");
        apply(0, 1, 0, 5'h10, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, "R7");
        apply(0, 1, 0, 5'h01, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, "R7");
        apply(0, 1, 0, 5'h08, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, "R7");
        apply(0, 1, 1, 5'h04, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, "R7");
        // R8 idle cycles carry no trap, back-to-back requests pulse individually
        apply(0, 0, 1, 5'h1F, 64'd1, 64'd2, "R8");
        apply(0, 1, 1, 5'h1F, 64'd1, 64'd2, "R8");
        apply(0, 1, 1, 5'h00, 64'd1, 64'd2, "R8");
        apply(0, 1, 1, 5'h1F, 64'd4, 64'd4, "R8");
        apply(0, 0, 0, 5'h1F, 64'd4, 64'd4, "R8");
        // R9 request during reset is dropped
        apply(1, 1, 1, 5'h1F, 64'd1, 64'd2, "R9");
        apply(0, 1, 1, 5'h1F, 64'd1, 64'd2, "R9");
        // R10 all-ones mask, both modes, random operands
        for (int i = 0; i < 40; i++) begin
            ra = {$urandom, $urandom};
            rb = (i % 4 == 0) ? ra : {$urandom, $urandom};
            apply(0, 1, i[0], 5'h1F, ra, rb, "R10");
        end
        // random masks across R1..R7
        for (int i = 0; i < 300; i++) begin
            ra = {$urandom, $urandom};
            rb = (i % 5 == 0) ? {~ra[63:32], ra[31:0]} : {$urandom, $urandom};
            apply(0, ($urandom % 4) != 0, i[1], 5'($urandom), ra, rb, "R1-R7 random");
        end
        apply(0, 0, 0, 5'h00, 64'd0, 64'd0, "R8");
        repeat (3) @(posedge clk_i);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule